// File: doc/BRIEF.md
# Card Presence and Stop-Mode Controller

This block watches the card-present switch of a smart card reader and drives an active-low status line back to the host controller. A card counts as present when either of two switch inputs reports it: one is active-high and one is active-low. Insertion is debounced over a programmable number of microsecond ticks. Removal is acted on at once. Inside a card session, a removal or a fault raises a single-cycle emergency deactivation request and forces the status line low. The status line stays low until the host ends the session.

The block also decodes a low-power stop mode. Stop mode is the otherwise unused combination in which the session command is idle and both supply-select inputs are high. While the block is in stop mode, the status line tracks the raw switch. On leaving stop mode, the status line is held low for a power-up delay and then for a full debounce interval. A new session is granted only while the status line is high. All external control inputs pass through a synchroniser. The busy signal from the deactivation sequencer is taken as already synchronous.

Top module: `card_presence_ctrl`

## Requirements
- R1: Card presence is `pres_hi_i` high OR `pres_lo_ni` low; either input alone reports the card.
- R2: After insertion, `status_no` rises to 1 only once presence has been stable for DEBOUNCE_US ticks of `tick_us_i`; it stays 0 before that.
- R3: A presence drop during the debounce interval restarts the count from zero.
- R4: During a session, a removal pulses `emerg_deact_o` for one clock and drives `status_no` to 0 within 4 clocks of the raw change.
- R5: Outside a session, `fault_i` has no effect (no emergency pulse, status unchanged), and a removal drops `status_no` to 0 without debounce.
- R6: During a session, `fault_i` pulses `emerg_deact_o` and latches `status_no` at 0; when the host sets `session_ni` high, `status_no` returns to 1 if the card is still present.
- R7: Stop mode (`stop_o`=1) is entered when `session_ni`, `vsel_a_i` and `vsel_b_i` are all 1, no session is active and `deact_busy_i` is 0; while `deact_busy_i` is 1, entry waits.
- R8: In stop mode, `status_no` follows raw presence with no debounce.
- R9: When any of the three control inputs goes low in stop mode, `stop_o` drops and `status_no` is held at 0 for WARMUP_US ticks. A full DEBOUNCE_US interval then follows before it can rise.
- R10: `sess_active_o` rises only when `session_ni` is 0 while `status_no` is 1; with no settled card, a session request is not granted.

Top module ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_us_i | input | 1 | One-cycle pulse per microsecond |
| pres_hi_i | input | 1 | Active-high card switch |
| pres_lo_ni | input | 1 | Active-low card switch |
| session_ni | input | 1 | Host session command, 0 requests a session |
| vsel_a_i | input | 1 | Supply select, higher-voltage choice |
| vsel_b_i | input | 1 | Supply select, lowest-voltage override |
| fault_i | input | 1 | Overcurrent or overheating fault |
| deact_busy_i | input | 1 | Deactivation sequence in progress |
| status_no | output | 1 | Active-low status/interrupt line to host |
| emerg_deact_o | output | 1 | One-cycle emergency deactivation request |
| sess_active_o | output | 1 | Session granted |
| stop_o | output | 1 | Stop mode, analog circuits gated |

## Verification
The bench builds the block with DEBOUNCE_US=20 and WARMUP_US=6, and pulses the tick every 4 clocks. These values bring the full power-up delay and debounce windows into a few hundred cycles. At that length, a check just before expiry and a check just after it both fit in the run. The scaled values also let the bench restart a debounce part-way through. They keep the combined warm-up-plus-debounce window after stop exit short enough to check both of its edges.

// File: rtl/card_pres_pkg.sv
package card_pres_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_STOP = 2'd1,
    PM_WARM = 2'd2
  } pwr_mode_e;

  localparam int unsigned SYNC_W = 5;
  localparam int unsigned S_PRES = 0;
  localparam int unsigned S_SESN = 1;
  localparam int unsigned S_VSA  = 2;
  localparam int unsigned S_VSB  = 3;
  localparam int unsigned S_FLT  = 4;
endpackage

// File: rtl/cp_sync.sv
module cp_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/cp_debounce.sv
module cp_debounce #(
  parameter int unsigned DEB_TICKS = 8000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hold_i,
  input  logic pres_i,
  output logic stable_o
);
  localparam int unsigned CNT_W = $clog2(DEB_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEB_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             prev_q;
  logic             stable_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      prev_q   <= 1'b0;
      stable_q <= 1'b0;
    end else begin
      prev_q <= pres_i;
      if (hold_i || !pres_i || (pres_i != prev_q)) begin
        // removal acts at once; any change restarts the interval
        cnt_q    <= '0;
        stable_q <= stable_q & pres_i & ~hold_i;
      end else if (!stable_q && tick_i) begin
        if (cnt_q == LAST) stable_q <= 1'b1;
        else               cnt_q    <= cnt_q + 1'b1;
      end
    end
  end

  assign stable_o = stable_q;

  p_drop_fast_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pres_i || hold_i) |=> !stable_o);

  p_rise_after_interval_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stable_o) |-> $past(cnt_q == LAST && tick_i && pres_i));
endmodule

// File: rtl/cp_stop_ctrl.sv
module cp_stop_ctrl
  import card_pres_pkg::*;
#(
  parameter int unsigned WARM_TICKS = 220
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      stop_req_i,
  input  logic      sess_i,
  input  logic      busy_i,
  output pwr_mode_e mode_o
);
  localparam int unsigned CNT_W = $clog2(WARM_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WARM_TICKS - 1);

  pwr_mode_e        mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    unique case (mode_q)
      PM_RUN: begin
        if (stop_req_i && !sess_i && !busy_i) mode_d = PM_STOP;
      end
      PM_STOP: begin
        if (!stop_req_i) begin
          mode_d = PM_WARM;
          cnt_d  = '0;
        end
      end
      PM_WARM: begin
        if (stop_req_i && !busy_i) begin
          mode_d = PM_STOP;
        end else if (tick_i) begin
          if (cnt_q == LAST) mode_d = PM_RUN;
          else               cnt_d  = cnt_q + 1'b1;
        end
      end
      default: mode_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PM_RUN;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mode_o = mode_q;

  p_entry_guard_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PM_STOP && $past(mode_q) == PM_RUN) |-> $past(stop_req_i && !sess_i && !busy_i));

  p_exit_via_warm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_q) == PM_STOP && mode_q != PM_STOP) |-> mode_q == PM_WARM);
endmodule

// File: rtl/cp_session.sv
module cp_session (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic allow_i,
  input  logic pres_i,
  input  logic fault_i,
  output logic sess_o,
  output logic alarm_o,
  output logic emerg_o
);
  logic sess_q, alarm_q, emerg_q;
  logic trip;

  assign trip = sess_q & req_i & (~pres_i | fault_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sess_q  <= 1'b0;
      alarm_q <= 1'b0;
      emerg_q <= 1'b0;
    end else begin
      if (!req_i)       sess_q <= 1'b0;
      else if (allow_i) sess_q <= 1'b1;
      if (!req_i || !sess_q) alarm_q <= 1'b0;
      else if (trip)         alarm_q <= 1'b1;
      emerg_q <= trip & ~alarm_q;
    end
  end

  assign sess_o  = sess_q;
  assign alarm_o = alarm_q;
  assign emerg_o = emerg_q;

  p_emerg_in_session_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emerg_o |-> sess_o && alarm_o);

  p_emerg_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emerg_o |=> !emerg_o);
endmodule

// File: rtl/card_presence_ctrl.sv
module card_presence_ctrl
  import card_pres_pkg::*;
#(
  parameter int unsigned DEBOUNCE_US = 8000,
  parameter int unsigned WARMUP_US   = 220,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_us_i,
  input  logic pres_hi_i,
  input  logic pres_lo_ni,
  input  logic session_ni,
  input  logic vsel_a_i,
  input  logic vsel_b_i,
  input  logic fault_i,
  input  logic deact_busy_i,
  output logic status_no,
  output logic emerg_deact_o,
  output logic sess_active_o,
  output logic stop_o
);
  localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(1) << S_SESN;

  logic [SYNC_W-1:0] raw, syn;
  logic              pres_s, sess_req, stop_req, fault_s;
  logic              deb_stable, sess, alarm, emerg;
  pwr_mode_e         mode;
  logic              status;

  assign raw[S_PRES] = pres_hi_i | ~pres_lo_ni;
  assign raw[S_SESN] = session_ni;
  assign raw[S_VSA]  = vsel_a_i;
  assign raw[S_VSB]  = vsel_b_i;
  assign raw[S_FLT]  = fault_i;

  cp_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  assign pres_s   = syn[S_PRES];
  assign sess_req = ~syn[S_SESN];
  assign stop_req = syn[S_SESN] & syn[S_VSA] & syn[S_VSB];
  assign fault_s  = syn[S_FLT];

  cp_debounce #(.DEB_TICKS(DEBOUNCE_US)) u_deb (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_us_i),
    .hold_i(mode != PM_RUN), .pres_i(pres_s), .stable_o(deb_stable)
  );

  cp_stop_ctrl #(.WARM_TICKS(WARMUP_US)) u_stop (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_us_i),
    .stop_req_i(stop_req), .sess_i(sess), .busy_i(deact_busy_i), .mode_o(mode)
  );

  cp_session u_sess (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(sess_req),
    .allow_i((mode == PM_RUN) && status), .pres_i(pres_s), .fault_i(fault_s),
    .sess_o(sess), .alarm_o(alarm), .emerg_o(emerg)
  );

  always_comb begin
    unique case (mode)
      PM_STOP: status = pres_s;
      PM_WARM: status = 1'b0;
      default: status = deb_stable & ~alarm;
    endcase
  end

  assign status_no     = status;
  assign emerg_deact_o = emerg;
  assign sess_active_o = sess;
  assign stop_o        = (mode == PM_STOP);

  p_start_needs_status_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sess_active_o) |-> $past(status_no));

  p_warm_unsettled_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == PM_WARM) |-> !deb_stable);

  p_no_stop_in_session_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stop_o && sess_active_o));
endmodule

// File: tb/card_presence_ctrl_tb.sv
module card_presence_ctrl_tb;
  localparam int DEB  = 20;
  localparam int WARM = 6;
  localparam int TDIV = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_us = 1'b0;
  logic pres_hi = 1'b0, pres_lo_n = 1'b1, session_n = 1'b1;
  logic vsel_a = 1'b0, vsel_b = 1'b0, fault = 1'b0, busy = 1'b0;
  logic status_n, emerg, sess_act, stop;

  int total = 0, bad = 0, emerg_cnt = 0, tdiv_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  card_presence_ctrl #(.DEBOUNCE_US(DEB), .WARMUP_US(WARM)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_us_i(tick_us),
    .pres_hi_i(pres_hi), .pres_lo_ni(pres_lo_n), .session_ni(session_n),
    .vsel_a_i(vsel_a), .vsel_b_i(vsel_b), .fault_i(fault), .deact_busy_i(busy),
    .status_no(status_n), .emerg_deact_o(emerg), .sess_active_o(sess_act), .stop_o(stop)
  );

  always @(negedge clk) begin
    tdiv_cnt <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
    tick_us  <= (tdiv_cnt == TDIV - 1);
  end

  always @(posedge clk) if (rst_ni && emerg) emerg_cnt <= emerg_cnt + 1;

  // scoreboard: sel 0=status 1=stop 2=session 3=emergency count
  typedef struct { string req; int sel; int val; } exp_t;
  exp_t exp_q[$];

  initial begin
    forever begin
      wait (exp_q.size() != 0);
      begin
        exp_t it;
        int act;
        it = exp_q.pop_front();
        case (it.sel)
          0: act = int'(status_n);
          1: act = int'(stop);
          2: act = int'(sess_act);
          default: act = emerg_cnt;
        endcase
        total++;
        if (act != it.val) begin
          bad++;
          $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, act, it.val);
        end
      end
    end
  end

  task automatic expect_v(input string req, input int sel, input int val);
    exp_t it;
    it.req = req; it.sel = sel; it.val = val;
    exp_q.push_back(it);
    #1;
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    clks(n * TDIV);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clks(3);
    rst_ni = 1'b1;
    clks(2);
    expect_v("reset R2", 0, 0);
    expect_v("reset R7", 1, 0);
    expect_v("reset R10", 2, 0);
    expect_v("reset R4", 3, 0);

    // R10: no card, session refused
    session_n = 1'b0; clks(8);
    expect_v("R10 refused", 2, 0);
    session_n = 1'b1; clks(4);

    // R2: insertion via active-high input
    pres_hi = 1'b1; ticks(10);
    expect_v("R2 before interval", 0, 0);
    ticks(15);
    expect_v("R2 after interval", 0, 1);

    // R1: hand over to active-low input, presence unchanged
    pres_lo_n = 1'b0; clks(1); pres_hi = 1'b0; ticks(5);
    expect_v("R1 low input alone", 0, 1);

    // R5: removal outside session, immediate
    pres_lo_n = 1'b1; clks(4);
    expect_v("R5 removal no debounce", 0, 0);
    expect_v("R5 no emergency", 3, 0);

    // R3: glitch restarts debounce
    pres_lo_n = 1'b0; ticks(10);
    pres_lo_n = 1'b1; clks(2); pres_lo_n = 1'b0;
    ticks(12);
    expect_v("R3 restarted", 0, 0);
    ticks(13);
    expect_v("R3 settles after restart", 0, 1);

    // R5: fault ignored outside session
    fault = 1'b1; clks(10);
    expect_v("R5 fault ignored status", 0, 1);
    expect_v("R5 fault ignored emerg", 3, 0);
    fault = 1'b0; clks(4);

    // R10: session granted with settled card
    session_n = 1'b0; clks(5);
    expect_v("R10 granted", 2, 1);

    // R6: fault in session
    fault = 1'b1; clks(3); fault = 1'b0; clks(4);
    expect_v("R6 emergency", 3, 1);
    expect_v("R6 status latched", 0, 0);
    session_n = 1'b1; clks(5);
    expect_v("R6 status back", 0, 1);
    expect_v("R6 session off", 2, 0);

    // R4: removal in session
    session_n = 1'b0; clks(5);
    pres_lo_n = 1'b1; clks(4);
    expect_v("R4 status low", 0, 0);
    clks(2);
    expect_v("R4 emergency", 3, 2);
    session_n = 1'b1; clks(4);
    expect_v("R4 still no card", 0, 0);

    // R7: stop entry waits for busy deactivation
    busy = 1'b1;
    vsel_a = 1'b1; clks(2); vsel_b = 1'b1; clks(6);
    expect_v("R7 held by busy", 1, 0);
    busy = 1'b0; clks(5);
    expect_v("R7 stop entered", 1, 1);

    // R8: raw presence in stop
    pres_hi = 1'b1; clks(4);
    expect_v("R8 follows insert", 0, 1);
    pres_hi = 1'b0; clks(4);
    expect_v("R8 follows removal", 0, 0);
    pres_hi = 1'b1; clks(4);

    // R9: exit -> warm-up then debounce
    vsel_b = 1'b0; clks(5);
    expect_v("R9 stop left", 1, 0);
    expect_v("R9 held low", 0, 0);
    ticks(21);
    expect_v("R9 still settling", 0, 0);
    ticks(11);
    expect_v("R9 settled", 0, 1);

    clks(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule